// File: doc/BRIEF.md
# Paged Audio Controller Register Bank

This block is the host-facing register storage for a three-channel audio engine with two playback channels and one record channel. The host reaches it through an 8-bit I/O offset. Each access is one cycle wide and carries a size of one, two or four bytes. Narrow writes are merged into the 32-bit registers they land in. Read data comes back, registered, on the following cycle.

The low part of the offset space is a flat window. It holds the control word, a read-only status word, a 4-bit page register, a codec command word, the serial-control word and one sample-count register per channel. The 16 offsets 0x30 to 0x3F form a window whose effective address has the page value placed above the 8-bit offset. Through that window, pages 0xC and 0xD reach a frame address and frame count register for each channel. A fourth slot on page 0xD has no storage behind it.

The datapath that moves audio samples needs to know when its configuration has moved. For that reason the block emits a one-cycle pulse whenever the control or serial-control value actually changes, and it exposes both values as outputs.

Top module: `pcm_regbank`

## Requirements
- R1: After reset, a long read gives 0x00000001 at offset 0x00 (control), 0x00000060 at 0x04 (status), and zero at 0x0C (page), 0x10 (codec) and 0x20 (serial control). The update pulse is low.
- R2: A byte write (size 1) to offsets 0x00–0x03 (control) or 0x20–0x23 (serial control) replaces byte lane n = offset[1:0], bits [8n+7:8n], with write data [7:0]. All other bits keep their value.
- R3: A word write (size 2) to control at offset 0x00 replaces bits [15:0], and at offset 0x02 it replaces bits [31:16], with write data [15:0].
- R4: A long write (size 4) to 0x00 or 0x20 replaces the whole register. A long or byte write to 0x0C stores only write data [3:0] as the page value.
- R5: A word or long write to a sample-count register (0x24 playback 1, 0x28 playback 2, 0x2C record) stores only data [15:0]. The upper half reads as zero and is unchanged by any write, including through a word read at offset +2.
- R6: For offsets 0x30–0x3F the effective address is the page value shifted left by 8, OR-ed with the offset. Other offsets ignore the page. With page 0 the window is unmapped.
- R7: Long writes and long reads reach frame address/count at effective 0xC30/0xC34 (playback 1), 0xC38/0xC3C (playback 2) and 0xD30/0xD34 (record). Word reads of a frame count return bits [15:0] at +0 and bits [31:16] at +2.
- R8: Effective addresses 0xD38 and 0xD3C ignore writes and read back as 0xFFFFFFFF.
- R9: A read that matches no register returns 0xFFFFFFFF. A byte read of offset 0x1B returns 0x00000005.
- R10: Every read (valid high, write low) gives a response valid pulse exactly one cycle later. A write gives no response.
- R11: The update pulse is high for one cycle, in the cycle after a write that changes control or serial control. A write that leaves both values unchanged gives no pulse.
- R12: A byte read of 0x00–0x03 or 0x04–0x07 returns that lane of control or status in data [7:0], with the upper bits zero. A word write to 0x10 stores data [15:0] as the codec word, and a long read returns it zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Access strobe, one cycle per access |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| req_off | input | 8 | I/O offset |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_vld | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data, right-aligned |
| ctrl_o | output | 32 | Current control word |
| sctl_o | output | 32 | Current serial-control word |
| cfg_upd | output | 1 | Pulse: control or serial control changed |

## Verification
Several properties are checked on every cycle: reads and responses stay paired one-to-one, the update pulse is only seen together with a real change of control or serial control, neither word moves without a write, the legacy byte reads as five, and the page-0xD phantom slot reads all ones. The bench scenarios are the only check of the lane merging, the page remapping onto the correct channel, the keeping of the low 16 bits of a sample count, the reset values, and the handling of unmapped offsets. For these, the bench compares each response with a value worked out from the requirements.

// File: rtl/pcm_regbank_pkg.sv
// Shared sizes, effective addresses and helpers for the paged audio register bank.
// Assumes an 8-bit offset, a 4-bit page and 32-bit registers.
package pcm_regbank_pkg;
    localparam int OFF_W  = 8;
    localparam int PAGE_W = 4;
    localparam int EXT_W  = OFF_W + PAGE_W;
    localparam int DW     = 32;
    localparam int CW     = 16;
    localparam int NCH    = 3;

    typedef enum logic [2:0] {
        SZ_BYTE = 3'd1,
        SZ_HALF = 3'd2,
        SZ_WORD = 3'd4
    } acc_size_e;

    localparam logic [EXT_W-1:0] A_CTRL   = 12'h000;
    localparam logic [EXT_W-1:0] A_STAT   = 12'h004;
    localparam logic [EXT_W-1:0] A_PAGE   = 12'h00C;
    localparam logic [EXT_W-1:0] A_CODEC  = 12'h010;
    localparam logic [EXT_W-1:0] A_LEGACY = 12'h01B;
    localparam logic [EXT_W-1:0] A_SCTL   = 12'h020;
    localparam logic [EXT_W-1:0] A_SCNT0  = 12'h024;

    localparam logic [DW-1:0] CTRL_RST = 32'h0000_0001;
    localparam logic [DW-1:0] STAT_RST = 32'h0000_0060;
    localparam logic [DW-1:0] LEGACY_V = 32'h0000_0005;

    // Frame address slot: 0xC30, 0xC38, 0xD30, 0xD38 (slot 3 is the empty one).
    function automatic logic [EXT_W-1:0] frame_base(input logic [1:0] slot);
        return {3'b110, slot[1], 4'b0011, slot[0], 3'b000};
    endfunction

    // Merge a byte, half or word write into an existing 32-bit register.
    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old,
                                                 input logic [DW-1:0] data,
                                                 input logic [2:0]    size,
                                                 input logic [1:0]    lane);
        logic [DW-1:0] res;
        res = old;
        if (size == SZ_BYTE)      res[{lane, 3'b000} +: 8]        = data[7:0];
        else if (size == SZ_HALF) res[{lane[1], 4'b0000} +: 16]   = data[15:0];
        else                      res                             = data;
        return res;
    endfunction
endpackage

// File: rtl/pcm_page_xlate.sv
// Page translation: offsets inside [WIN_LO, WIN_HI] get the page value placed
// above the offset bits; other offsets pass through with a zero page.
// Assumes the offset is narrower than the effective address by PAGE_W bits.
module pcm_page_xlate #(
    parameter int OFF_W  = 8,
    parameter int PAGE_W = 4,
    parameter logic [OFF_W-1:0] WIN_LO = 8'h30,
    parameter logic [OFF_W-1:0] WIN_HI = 8'h3F,
    localparam int EXT_W = OFF_W + PAGE_W
) (
    input  logic [OFF_W-1:0]  off,
    input  logic [PAGE_W-1:0] page,
    output logic [EXT_W-1:0]  ext
);
    logic in_win;

    // Form the effective address from offset and, inside the window, the page.
    always_comb begin
        in_win = (off >= WIN_LO) && (off <= WIN_HI);
        ext    = {(in_win ? page : {PAGE_W{1'b0}}), off};
    end
endmodule

// File: rtl/pcm_cfg_regs.sv
// Control, serial-control, page and codec storage with lane merging and the
// change pulse. Assumes the caller has already decoded offset and size.
module pcm_cfg_regs
    import pcm_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     wdata,
    input  logic [2:0]        size,
    input  logic [1:0]        lane,
    input  logic              ctrl_we,
    input  logic              sctl_we,
    input  logic              page_we,
    input  logic              codec_we,
    output logic [DW-1:0]     ctrl_q,
    output logic [DW-1:0]     sctl_q,
    output logic [PAGE_W-1:0] page_q,
    output logic [CW-1:0]     codec_q,
    output logic              upd_q
);
    logic [DW-1:0] ctrl_d, sctl_d;

    // Next values of the two merged configuration words.
    always_comb begin
        ctrl_d = ctrl_we ? lane_merge(ctrl_q, wdata, size, lane) : ctrl_q;
        sctl_d = sctl_we ? lane_merge(sctl_q, wdata, size, lane) : sctl_q;
    end

    // Register update and one-cycle change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            sctl_q  <= '0;
            page_q  <= '0;
            codec_q <= '0;
            upd_q   <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            sctl_q <= sctl_d;
            upd_q  <= (ctrl_d != ctrl_q) || (sctl_d != sctl_q);
            if (page_we)  page_q  <= wdata[PAGE_W-1:0];
            if (codec_we) codec_q <= wdata[CW-1:0];
        end
    end
endmodule

// File: rtl/pcm_chan_bank.sv
// Per-channel sample-count (low half only), frame address and frame count
// storage. Assumes the caller gives exclusive write strobes per register.
module pcm_chan_bank
    import pcm_regbank_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DW-1:0]         wdata,
    input  logic [N-1:0]          scnt_we,
    input  logic [N-1:0]          faddr_we,
    input  logic [N-1:0]          fcnt_we,
    output logic [N-1:0][CW-1:0]  scnt_lo,
    output logic [N-1:0][DW-1:0]  faddr,
    output logic [N-1:0][DW-1:0]  fcnt
);
    for (genvar ch = 0; ch < N; ch++) begin : g_ch
        // Storage for one channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                scnt_lo[ch] <= '0;
                faddr[ch]   <= '0;
                fcnt[ch]    <= '0;
            end else begin
                if (scnt_we[ch])  scnt_lo[ch] <= wdata[CW-1:0];
                if (faddr_we[ch]) faddr[ch]   <= wdata;
                if (fcnt_we[ch])  fcnt[ch]    <= wdata;
            end
        end
    end
endmodule

// File: rtl/pcm_regbank.sv
// Top of the paged audio register bank: decodes size and effective address,
// steers writes to the storage blocks, and returns registered read data.
// Assumes one access per cycle, and a size value of 1, 2 or 4 for a write.
module pcm_regbank
    import pcm_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_vld,
    input  logic        req_wr,
    input  logic [2:0]  req_size,
    input  logic [7:0]  req_off,
    input  logic [31:0] req_wdata,
    output logic        rsp_vld,
    output logic [31:0] rsp_rdata,
    output logic [31:0] ctrl_o,
    output logic [31:0] sctl_o,
    output logic        cfg_upd
);
    logic [EXT_W-1:0]      ext;
    logic [PAGE_W-1:0]     page_q;
    logic [CW-1:0]         codec_q;
    logic                  is_b, is_h, is_w, wr_ok, rd;
    logic                  ctrl_we, sctl_we, page_we, codec_we;
    logic [NCH-1:0]        scnt_we, faddr_we, fcnt_we;
    logic [NCH-1:0][CW-1:0] scnt_lo;
    logic [NCH-1:0][DW-1:0] faddr, fcnt;
    logic [DW-1:0]         rd_d, stat_v;

    pcm_page_xlate #(.OFF_W(OFF_W), .PAGE_W(PAGE_W)) u_xlate (
        .off(req_off), .page(page_q), .ext(ext)
    );

    // Size and direction qualifiers, plus write-strobe decode.
    always_comb begin
        is_b  = (req_size == SZ_BYTE);
        is_h  = (req_size == SZ_HALF);
        is_w  = (req_size == SZ_WORD);
        wr_ok = req_vld && req_wr && (is_b || is_h || is_w);
        rd    = req_vld && !req_wr;
        ctrl_we  = wr_ok && (ext[EXT_W-1:2] == A_CTRL[EXT_W-1:2]) &&
                   (is_b || (is_h && !ext[0]) || (is_w && ext[1:0] == 2'b00));
        sctl_we  = wr_ok && (ext[EXT_W-1:2] == A_SCTL[EXT_W-1:2]) &&
                   (is_b || (is_w && ext[1:0] == 2'b00));
        page_we  = wr_ok && (ext == A_PAGE) && (is_b || is_w);
        codec_we = wr_ok && (ext == A_CODEC) && is_h;
        for (int ch = 0; ch < NCH; ch++) begin
            scnt_we[ch]  = wr_ok && (is_h || is_w) && (ext == A_SCNT0 + EXT_W'(4 * ch));
            faddr_we[ch] = wr_ok && is_w && (ext == frame_base(2'(ch)));
            fcnt_we[ch]  = wr_ok && is_w && (ext == (frame_base(2'(ch)) | EXT_W'(4)));
        end
    end

    pcm_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .wdata(req_wdata), .size(req_size),
        .lane(ext[1:0]), .ctrl_we(ctrl_we), .sctl_we(sctl_we),
        .page_we(page_we), .codec_we(codec_we), .ctrl_q(ctrl_o),
        .sctl_q(sctl_o), .page_q(page_q), .codec_q(codec_q), .upd_q(cfg_upd)
    );

    pcm_chan_bank #(.N(NCH)) u_chan (
        .clk(clk), .rst_n(rst_n), .wdata(req_wdata), .scnt_we(scnt_we),
        .faddr_we(faddr_we), .fcnt_we(fcnt_we), .scnt_lo(scnt_lo),
        .faddr(faddr), .fcnt(fcnt)
    );

    // Read mux; anything unmatched, phantom slot included, reads all ones.
    always_comb begin
        rd_d   = '1;
        stat_v = STAT_RST;
        if (is_w) begin
            if (ext == A_CTRL)       rd_d = ctrl_o;
            else if (ext == A_STAT)  rd_d = stat_v;
            else if (ext == A_PAGE)  rd_d = DW'(page_q);
            else if (ext == A_CODEC) rd_d = DW'(codec_q);
            else if (ext == A_SCTL)  rd_d = sctl_o;
            for (int ch = 0; ch < NCH; ch++) begin
                if (ext == A_SCNT0 + EXT_W'(4 * ch))               rd_d = DW'(scnt_lo[ch]);
                if (ext == frame_base(2'(ch)))                     rd_d = faddr[ch];
                if (ext == (frame_base(2'(ch)) | EXT_W'(4)))       rd_d = fcnt[ch];
            end
        end else if (is_h) begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (ext == A_SCNT0 + EXT_W'(4 * ch + 2))           rd_d = '0;
                if (ext == (frame_base(2'(ch)) | EXT_W'(4)))       rd_d = DW'(fcnt[ch][15:0]);
                if (ext == (frame_base(2'(ch)) | EXT_W'(6)))       rd_d = DW'(fcnt[ch][31:16]);
            end
        end else if (is_b) begin
            if (ext[EXT_W-1:2] == A_CTRL[EXT_W-1:2])      rd_d = DW'(ctrl_o[{ext[1:0], 3'b000} +: 8]);
            else if (ext[EXT_W-1:2] == A_STAT[EXT_W-1:2]) rd_d = DW'(stat_v[{ext[1:0], 3'b000} +: 8]);
            else if (ext == A_PAGE)                       rd_d = DW'(page_q);
            else if (ext == A_LEGACY)                     rd_d = LEGACY_V;
        end
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_vld <= rd;
            if (rd) rsp_rdata <= rd_d;
        end
    end

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_wr) |=> rsp_vld);                                       // R10
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_vld && !req_wr) |=> !rsp_vld);                                     // R10
    AST_UPD_REAL_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cfg_upd) |-> (!$stable(ctrl_o) || !$stable(sctl_o)));   // R11
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(req_vld && req_wr)) |-> ($stable(ctrl_o) && $stable(sctl_o))); // R4
    AST_PHANTOM_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_vld && !req_wr && page_q == 4'hD && req_off[7:3] == 5'b00111))
        |-> (rsp_rdata == 32'hFFFF_FFFF));                                       // R8
    AST_LEGACY_FIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_vld && !req_wr && req_size == 3'd1 && req_off == 8'h1B))
        |-> (rsp_rdata == 32'h5));                                               // R9
endmodule

// File: tb/sim_pcm_regbank.sv
`timescale 1ns/1ps
module sim_pcm_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0, req_wr = 1'b0;
    logic [2:0]  req_size = 3'd4;
    logic [7:0]  req_off = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_vld, cfg_upd;
    logic [31:0] rsp_rdata, ctrl_o, sctl_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    int          cyc_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pcm_regbank u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
        .req_size(req_size), .req_off(req_off), .req_wdata(req_wdata),
        .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata), .ctrl_o(ctrl_o),
        .sctl_o(sctl_o), .cfg_upd(cfg_upd)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: a write, then the pulse and no-response checks one cycle later.
    task automatic wr(input logic [7:0] off, input logic [2:0] sz,
                      input logic [31:0] d, input logic exp_upd, input string tag);
        @(negedge clk);
        req_vld = 1; req_wr = 1; req_off = off; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_vld = 0; req_wr = 0;
        chk({31'b0, cfg_upd}, {31'b0, exp_upd}, {tag, " upd"});
        chk({31'b0, rsp_vld}, 32'h0, "R10 no rsp on write");
    endtask

    // Driver: a read; the expected item goes to the scoreboard.
    task automatic rd(input logic [7:0] off, input logic [2:0] sz,
                      input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_vld = 1; req_wr = 0; req_off = off; req_size = sz;
        exp_q.push_back(exp); tag_q.push_back(tag); cyc_q.push_back(cyc);
        @(negedge clk);
        req_vld = 0;
    endtask

    // Monitor: pop and compare every response, and its latency (R10).
    always @(negedge clk) begin
        if (rst_n && rsp_vld) begin
            if (exp_q.size() == 0) begin
                chk(32'h1, 32'h0, "R10 unexpected response");
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                automatic int c = cyc_q.pop_front();
                chk(rsp_rdata, e, t);
                chk(cyc, c + 1, "R10 latency");
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(ctrl_o, 32'h1, "R1 ctrl port");
        chk(sctl_o, 32'h0, "R1 sctl port");
        chk({31'b0, cfg_upd}, 32'h0, "R1 upd");
        rd(8'h00, 3'd4, 32'h0000_0001, "R1 ctrl");
        rd(8'h04, 3'd4, 32'h0000_0060, "R1 status");
        rd(8'h0C, 3'd4, 32'h0, "R1 page");
        rd(8'h10, 3'd4, 32'h0, "R1 codec");
        rd(8'h20, 3'd4, 32'h0, "R1 sctl");

        wr(8'h02, 3'd1, 32'hAB, 1'b1, "R2 ctrl lane2");
        chk(ctrl_o, 32'h00AB_0001, "R2 ctrl port");
        rd(8'h00, 3'd4, 32'h00AB_0001, "R2 ctrl lane2");
        wr(8'h21, 3'd1, 32'h5A, 1'b1, "R2 sctl lane1");
        rd(8'h20, 3'd4, 32'h0000_5A00, "R2 sctl lane1");

        wr(8'h02, 3'd2, 32'h1234, 1'b1, "R3 ctrl high half");
        rd(8'h00, 3'd4, 32'h1234_0001, "R3 ctrl high half");
        wr(8'h00, 3'd2, 32'hBEEF, 1'b1, "R3 ctrl low half");
        rd(8'h00, 3'd4, 32'h1234_BEEF, "R3 ctrl low half");

        wr(8'h00, 3'd4, 32'h1234_BEEF, 1'b0, "R11 same ctrl");
        wr(8'h21, 3'd1, 32'h5A, 1'b0, "R11 same sctl byte");

        wr(8'h20, 3'd4, 32'hCAFE_0000, 1'b1, "R4 sctl long");
        chk(sctl_o, 32'hCAFE_0000, "R4 sctl port");
        rd(8'h20, 3'd4, 32'hCAFE_0000, "R4 sctl long");
        wr(8'h0C, 3'd4, 32'hFFFF_FFFC, 1'b0, "R4 page long");
        rd(8'h0C, 3'd4, 32'h0000_000C, "R4 page low bits");
        rd(8'h0C, 3'd1, 32'h0000_000C, "R4 page byte read");

        wr(8'h24, 3'd4, 32'hABCD_1234, 1'b0, "R5 scount long");
        rd(8'h24, 3'd4, 32'h0000_1234, "R5 scount low only");
        wr(8'h28, 3'd2, 32'h7777, 1'b0, "R5 scount word");
        rd(8'h28, 3'd4, 32'h0000_7777, "R5 scount word");
        rd(8'h2A, 3'd2, 32'h0, "R5 scount upper half");
        wr(8'h2C, 3'd4, 32'hFFFF_0001, 1'b0, "R5 rec scount");
        rd(8'h2C, 3'd4, 32'h0000_0001, "R5 rec scount");

        wr(8'h30, 3'd4, 32'h1111_2222, 1'b0, "R7 p1 addr");
        wr(8'h34, 3'd4, 32'h3333_4444, 1'b0, "R7 p1 count");
        wr(8'h38, 3'd4, 32'h5555_6666, 1'b0, "R7 p2 addr");
        wr(8'h3C, 3'd4, 32'h7777_8888, 1'b0, "R7 p2 count");
        rd(8'h30, 3'd4, 32'h1111_2222, "R7 p1 addr");
        rd(8'h34, 3'd4, 32'h3333_4444, "R7 p1 count");
        rd(8'h38, 3'd4, 32'h5555_6666, "R7 p2 addr");
        rd(8'h3C, 3'd4, 32'h7777_8888, "R7 p2 count");
        rd(8'h34, 3'd2, 32'h0000_4444, "R7 count low word");
        rd(8'h36, 3'd2, 32'h0000_3333, "R7 count high word");
        rd(8'h3E, 3'd2, 32'h0000_7777, "R7 p2 count high word");

        wr(8'h0C, 3'd1, 32'h0D, 1'b0, "R6 page D");
        wr(8'h30, 3'd4, 32'h9999_AAAA, 1'b0, "R6 rec addr");
        wr(8'h34, 3'd4, 32'hBBBB_CCCC, 1'b0, "R6 rec count");
        wr(8'h38, 3'd4, 32'h1234_5678, 1'b0, "R8 phantom addr");
        wr(8'h3C, 3'd4, 32'h0000_0001, 1'b0, "R8 phantom count");
        rd(8'h30, 3'd4, 32'h9999_AAAA, "R6 rec addr");
        rd(8'h34, 3'd4, 32'hBBBB_CCCC, "R6 rec count");
        rd(8'h38, 3'd4, 32'hFFFF_FFFF, "R8 phantom addr");
        rd(8'h3C, 3'd4, 32'hFFFF_FFFF, "R8 phantom count");
        wr(8'h0C, 3'd1, 32'h0C, 1'b0, "R6 page C");
        rd(8'h30, 3'd4, 32'h1111_2222, "R6 page C untouched");
        wr(8'h0C, 3'd4, 32'h0, 1'b0, "R6 page 0");
        rd(8'h30, 3'd4, 32'hFFFF_FFFF, "R6 page 0 unmapped");

        rd(8'h1B, 3'd1, 32'h0000_0005, "R9 legacy byte");
        rd(8'h40, 3'd4, 32'hFFFF_FFFF, "R9 unmapped long");
        rd(8'h00, 3'd2, 32'hFFFF_FFFF, "R9 unmapped word");
        rd(8'h08, 3'd4, 32'hFFFF_FFFF, "R9 unmapped 08");

        rd(8'h03, 3'd1, 32'h0000_0012, "R12 ctrl lane3");
        rd(8'h04, 3'd1, 32'h0000_0060, "R12 status lane0");
        rd(8'h05, 3'd1, 32'h0000_0000, "R12 status lane1");
        wr(8'h10, 3'd2, 32'h5A5A, 1'b0, "R12 codec");
        rd(8'h10, 3'd4, 32'h0000_5A5A, "R12 codec");

        repeat (3) @(negedge clk);
        chk(exp_q.size(), 0, "R10 all reads answered");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule